// File: doc/BRIEF.md
# Restart Interrupt Vector Controller

This block is the interrupt front end of a small 8-bit processor core. It gathers four hardware interrupt sources and one restart request, and it holds the interrupt-enable flip-flop. From these it selects the one request the core should service next, and it presents that request as a flag together with a 16-bit restart address. The four hardware sources are a non-maskable trap and three maskable levels named 7.5, 6.5 and 5.5. The restart request carries a 3-bit restart number and comes from software or from an external device.

The trap input and level 7.5 are edge-triggered. A rising edge on either one sets a pending latch, and that latch stays set until the core acknowledges the request. Levels 6.5 and 5.5 are level-sensitive: a request exists only while the input is high. The core controls the enable flip-flop with three signals. `ei_cmd` arms it, and `instr_done` marks the end of each later instruction, so the flip-flop sets only when the instruction after the enable command has completed. `di_cmd` clears it. The block also tracks a halt state, which the core enters with `halt_cmd`. Any interrupt that the block offers releases the halt.

The request towards the core is a valid/ready pair. The block drives `irq_valid` and `irq_vector`, and the acknowledge is the cycle in which `irq_valid` and `irq_ready` are both high. The core may hold `irq_ready` low for any number of cycles. While it waits, a newly arriving request of higher priority can replace the vector on offer. The request serviced is always the one shown in the acknowledge cycle. The restart input is also a valid/ready pair. A requester holds `sw_valid` and `sw_num` steady, and `sw_ready` pulses in the cycle in which the core acknowledges that restart.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While enable is set and no hardware request is pending, a held restart request with number n gives `irq_valid`=1 and `irq_vector` = n*8, which spans 0x0000 to 0x0038.
- R2: The hardware sources use these vectors: trap 0x0024, level 5.5 0x002C, level 6.5 0x0034, level 7.5 0x003C.
- R3: When several requests are active at once, the vector offered is chosen in this priority order: trap, then 7.5, then 6.5, then 5.5, then the restart request.
- R4: A pending trap is offered even while the enable flip-flop is clear.
- R5: While enable is clear, the 7.5, 6.5 and 5.5 levels and the restart request cause no `irq_valid`.
- R6: After a one-cycle `ei_cmd`, `int_enabled` stays 0 until the next `instr_done` pulse, and it reads 1 in the cycle after that pulse.
- R7: `di_cmd` clears `int_enabled` on the next edge and cancels an enable that is armed but not yet in effect.
- R8: Every acknowledge (`irq_valid` and `irq_ready` both high) clears `int_enabled` on the next edge, whatever the source.
- R9: A rising edge on trap or on 7.5 is held as pending after the input falls and is cleared by the acknowledge of that source. An input that stays high across the acknowledge raises no second request.
- R10: Levels 6.5 and 5.5 request only while their input is high. When the input drops, the request is gone in the same cycle.
- R11: After reset, `int_enabled`, `irq_valid`, `halted` and `sw_ready` are all 0.
- R12: `halt_cmd` sets `halted`. The first cycle with `irq_valid` high clears `halted` on the next edge, and a masked request leaves `halted` set.
- R13: `sw_ready` is high only in an acknowledge cycle in which the restart request is the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Non-maskable trap, edge-captured |
| lvl75_in | input | 1 | Maskable level 7.5, edge-captured |
| lvl65_in | input | 1 | Maskable level 6.5, level-sensitive |
| lvl55_in | input | 1 | Maskable level 5.5, level-sensitive |
| sw_valid | input | 1 | Restart request present |
| sw_num | input | 3 | Restart number 0 to 7 |
| sw_ready | output | 1 | Restart request acknowledged this cycle |
| ei_cmd | input | 1 | Enable command (one-cycle pulse) |
| di_cmd | input | 1 | Disable command (one-cycle pulse) |
| instr_done | input | 1 | End of an instruction (one-cycle pulse) |
| halt_cmd | input | 1 | Core enters the halt state |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_vector | output | 16 | Restart address of the offered interrupt |
| irq_ready | input | 1 | Core accepts the offered interrupt |
| int_enabled | output | 1 | State of the interrupt-enable flip-flop |
| halted | output | 1 | Core is in the halt state |

## Verification
The assertions check these rules on every cycle:
- An offer made while enable is clear always carries the trap vector.
- Every acknowledge and every disable command leaves enable clear.
- Enable only ever rises right after an `instr_done` pulse.
- Every vector falls inside the restart area.
- `sw_ready` appears only inside an acknowledge of a held restart request.
- An offer always ends the halt state.

The directed scenarios show what needs a history of stimulus: the exact vector for each source and each restart number, the priority order when requests overlap, the delay of one instruction before enable takes effect, edge capture that survives a falling input but does not re-arm on a held level, and the way a level request vanishes as its input drops.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_L75  = 3'd2,
    SRC_L65  = 3'd3,
    SRC_L55  = 3'd4,
    SRC_SW   = 3'd5
  } irq_src_e;

  // Index of each edge-captured source in the latch array
  localparam int EDGE_TRAP = 0;
  localparam int EDGE_L75  = 1;
  localparam int NUM_EDGE  = 2;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic pend
);

  logic din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      din_q <= din;
      // a fresh edge wins over a clear in the same cycle
      if (din && !din_q) pend <= 1'b1;
      else if (clr)      pend <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_cmd,
  input  logic di_cmd,
  input  logic instr_done,
  input  logic ack,
  output logic ie
);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      armed <= 1'b0;
    end else if (di_cmd || ack) begin
      ie    <= 1'b0;
      armed <= 1'b0;
    end else if (ei_cmd) begin
      armed <= 1'b1;
    end else if (armed && instr_done) begin
      ie    <= 1'b1;
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int NUM_W      = 3,
  parameter int STEP_SHIFT = 3,
  parameter logic [VEC_W-1:0] TRAP_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] L75_VEC  = 16'h003C,
  parameter logic [VEC_W-1:0] L65_VEC  = 16'h0034,
  parameter logic [VEC_W-1:0] L55_VEC  = 16'h002C
) (
  input  logic             trap_p,
  input  logic             l75_p,
  input  logic             l65,
  input  logic             l55,
  input  logic             sw_req,
  input  logic [NUM_W-1:0] sw_num,
  input  logic             ie,
  output logic             valid,
  output logic [VEC_W-1:0] vector,
  output irq_src_e         src
);

  localparam int PAD_W = VEC_W - NUM_W - STEP_SHIFT;

  logic [VEC_W-1:0] sw_vec;
  assign sw_vec = {{PAD_W{1'b0}}, sw_num, {STEP_SHIFT{1'b0}}};

  always_comb begin
    src    = SRC_NONE;
    vector = '0;
    if (trap_p) begin
      src = SRC_TRAP; vector = TRAP_VEC;
    end else if (ie) begin
      if (l75_p) begin
        src = SRC_L75; vector = L75_VEC;
      end else if (l65) begin
        src = SRC_L65; vector = L65_VEC;
      end else if (l55) begin
        src = SRC_L55; vector = L55_VEC;
      end else if (sw_req) begin
        src = SRC_SW;  vector = sw_vec;
      end
    end
    valid = (src != SRC_NONE);
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int NUM_W      = 3,
  parameter int STEP_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             lvl75_in,
  input  logic             lvl65_in,
  input  logic             lvl55_in,
  input  logic             sw_valid,
  input  logic [NUM_W-1:0] sw_num,
  output logic             sw_ready,
  input  logic             ei_cmd,
  input  logic             di_cmd,
  input  logic             instr_done,
  input  logic             halt_cmd,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ready,
  output logic             int_enabled,
  output logic             halted
);

  logic [NUM_EDGE-1:0] edge_in, edge_clr, edge_pend;
  irq_src_e sel_src;
  logic     ack;

  assign ack = irq_valid && irq_ready;
  assign edge_in[EDGE_TRAP]  = trap_in;
  assign edge_in[EDGE_L75]   = lvl75_in;
  assign edge_clr[EDGE_TRAP] = ack && (sel_src == SRC_TRAP);
  assign edge_clr[EDGE_L75]  = ack && (sel_src == SRC_L75);

  for (genvar gi = 0; gi < NUM_EDGE; gi++) begin : g_edge
    irq_edge_latch u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (edge_in[gi]),
      .clr  (edge_clr[gi]),
      .pend (edge_pend[gi])
    );
  end

  irq_enable_ctl u_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .ei_cmd    (ei_cmd),
    .di_cmd    (di_cmd),
    .instr_done(instr_done),
    .ack       (ack),
    .ie        (int_enabled)
  );

  irq_arbiter #(
    .VEC_W     (VEC_W),
    .NUM_W     (NUM_W),
    .STEP_SHIFT(STEP_SHIFT)
  ) u_arb (
    .trap_p(edge_pend[EDGE_TRAP]),
    .l75_p (edge_pend[EDGE_L75]),
    .l65   (lvl65_in),
    .l55   (lvl55_in),
    .sw_req(sw_valid),
    .sw_num(sw_num),
    .ie    (int_enabled),
    .valid (irq_valid),
    .vector(irq_vector),
    .src   (sel_src)
  );

  assign sw_ready = ack && (sel_src == SRC_SW);

  always_ff @(posedge clk) begin
    if (!rst_n)         halted <= 1'b0;
    else if (irq_valid) halted <= 1'b0;
    else if (halt_cmd)  halted <= 1'b1;
  end

endmodule

// File: rtl/irq_vector_checker.sv
module irq_vector_checker #(
  parameter int VEC_W = 16,
  parameter int NUM_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_valid,
  input logic             sw_ready,
  input logic             di_cmd,
  input logic             instr_done,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_ready,
  input logic             int_enabled,
  input logic             halted
);

  p_masked_only_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !int_enabled) |-> (irq_vector == 16'h0024));

  p_ack_clears_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !int_enabled);

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    di_cmd |=> !int_enabled);

  p_enable_after_instr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_enabled) |-> $past(instr_done));

  p_vector_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[VEC_W-1:6] == '0 && irq_vector[1:0] == 2'b00));

  p_sw_ready_in_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ready |-> (irq_valid && irq_ready && sw_valid));

  p_offer_wakes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !halted);

endmodule

bind irq_vector_ctrl irq_vector_checker #(.VEC_W(VEC_W), .NUM_W(NUM_W)) u_checker (.*);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_in = 0, lvl75_in = 0, lvl65_in = 0, lvl55_in = 0;
  logic        sw_valid = 0;
  logic [2:0]  sw_num = '0;
  logic        sw_ready;
  logic        ei_cmd = 0, di_cmd = 0, instr_done = 0, halt_cmd = 0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic        irq_ready = 0;
  logic        int_enabled, halted;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trap_in(trap_in), .lvl75_in(lvl75_in), .lvl65_in(lvl65_in), .lvl55_in(lvl55_in),
    .sw_valid(sw_valid), .sw_num(sw_num), .sw_ready(sw_ready),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .instr_done(instr_done), .halt_cmd(halt_cmd),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ready(irq_ready),
    .int_enabled(int_enabled), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // every drive happens just after a falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_enable();
    step(); ei_cmd = 1;
    step(); ei_cmd = 0; instr_done = 1;
    step(); instr_done = 0;
  endtask

  task automatic do_ack();
    step(); irq_ready = 1;
    step(); irq_ready = 0;
  endtask

  task automatic t_reset();
    settle();
    chk_eq("R11 enable", int_enabled, 0);
    chk_eq("R11 valid", irq_valid, 0);
    chk_eq("R11 halted", halted, 0);
    chk_eq("R11 sw_ready", sw_ready, 0);
  endtask

  task automatic t_enable_delay();
    step(); ei_cmd = 1;
    step(); ei_cmd = 0;
    chk_eq("R6 not yet", int_enabled, 0);
    step(); chk_eq("R6 still waiting", int_enabled, 0);
    instr_done = 1;
    step(); instr_done = 0;
    chk_eq("R6 enabled", int_enabled, 1);
    step(); di_cmd = 1;
    step(); di_cmd = 0;
    chk_eq("R7 disabled", int_enabled, 0);
  endtask

  task automatic t_disable_cancels();
    step(); ei_cmd = 1;
    step(); ei_cmd = 0; di_cmd = 1;
    step(); di_cmd = 0; instr_done = 1;
    step(); instr_done = 0;
    chk_eq("R7 armed enable cancelled", int_enabled, 0);
  endtask

  task automatic t_restart();
    do_enable();
    sw_valid = 1; sw_num = 3'd5; settle();
    chk_eq("R1 valid", irq_valid, 1);
    chk_eq("R1 vector n=5", irq_vector, 16'h0028);
    sw_num = 3'd7; settle();
    chk_eq("R1 vector n=7", irq_vector, 16'h0038);
    sw_num = 3'd0; settle();
    chk_eq("R1 vector n=0", irq_vector, 16'h0000);
    chk_eq("R13 no ready before ack", sw_ready, 0);
    step(); irq_ready = 1; settle();
    chk_eq("R13 ready on ack", sw_ready, 1);
    step(); irq_ready = 0;
    chk_eq("R8 ack clears enable", int_enabled, 0);
    chk_eq("R5 request masked after ack", irq_valid, 0);
    sw_valid = 0;
  endtask

  task automatic t_masked();
    lvl65_in = 1; lvl55_in = 1; sw_valid = 1; sw_num = 3'd2;
    step(); step(); settle();
    chk_eq("R5 masked levels", irq_valid, 0);
    lvl75_in = 1;
    step(); settle();
    chk_eq("R5 masked 7.5", irq_valid, 0);
    lvl75_in = 0; lvl65_in = 0; lvl55_in = 0; sw_valid = 0;
    // the 7.5 edge stays pending while masked; release it
    do_enable(); settle();
    chk_eq("R9 masked edge held", irq_vector, 16'h003C);
    do_ack();
  endtask

  task automatic t_levels();
    do_enable();
    sw_valid = 1; sw_num = 3'd1; lvl55_in = 1; settle();
    chk_eq("R2 vector 5.5", irq_vector, 16'h002C);
    lvl65_in = 1; settle();
    chk_eq("R3 6.5 over 5.5", irq_vector, 16'h0034);
    lvl65_in = 0; settle();
    chk_eq("R10 6.5 dropped", irq_vector, 16'h002C);
    lvl55_in = 0; settle();
    chk_eq("R3 restart lowest", irq_vector, 16'h0008);
    sw_valid = 0; settle();
    chk_eq("R10 all dropped", irq_valid, 0);
    step(); di_cmd = 1;
    step(); di_cmd = 0;
  endtask

  task automatic t_edge75();
    do_enable();
    lvl75_in = 1;
    step(); lvl75_in = 0; lvl55_in = 1; lvl65_in = 1;
    step(); settle();
    chk_eq("R9 7.5 held after fall", irq_vector, 16'h003C);
    chk_eq("R3 7.5 over 6.5", irq_valid, 1);
    lvl65_in = 0; lvl55_in = 0;
    lvl75_in = 1;
    do_ack();
    do_enable();
    lvl55_in = 1; settle();
    chk_eq("R9 held level no retrigger", irq_vector, 16'h002C);
    lvl55_in = 0; lvl75_in = 0;
    step(); di_cmd = 1;
    step(); di_cmd = 0;
  endtask

  task automatic t_trap();
    trap_in = 1;
    step(); trap_in = 0;
    step(); settle();
    chk_eq("R4 trap while disabled", irq_valid, 1);
    chk_eq("R2 trap vector", irq_vector, 16'h0024);
    lvl75_in = 1;
    step(); lvl75_in = 0;
    do_enable(); settle();
    chk_eq("R3 trap over 7.5", irq_vector, 16'h0024);
    do_ack(); settle();
    chk_eq("R8 trap ack clears enable", int_enabled, 0);
    do_enable(); settle();
    chk_eq("R9 trap cleared, 7.5 next", irq_vector, 16'h003C);
    do_ack(); settle();
    chk_eq("R9 7.5 cleared by ack", irq_valid, 0);
  endtask

  task automatic t_halt();
    step(); halt_cmd = 1;
    step(); halt_cmd = 0;
    chk_eq("R12 halted", halted, 1);
    lvl65_in = 1;
    step(); step();
    chk_eq("R12 masked keeps halt", halted, 1);
    lvl65_in = 0; trap_in = 1;
    step(); trap_in = 0;
    step();
    chk_eq("R12 released by trap", halted, 0);
    do_ack();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_enable_delay();
    t_disable_cancels();
    t_restart();
    t_masked();
    t_levels();
    t_edge75();
    t_trap();
    t_halt();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      report();
    end
  end

endmodule